// File: doc/BRIEF.md
# Integer ALU with Condition Flag Update

This block is a 32-bit integer execution stage. It holds four general registers and a status word. Six operations are supported: add, subtract, compare, OR, XOR and bit-test. Add, subtract, OR and XOR write a result into a destination register. Compare and bit-test change only the flags. The zero, negative, carry and overflow flags are updated on the same clock edge as the register write.

Register indices are two-bit fields taken from an instruction word. One of four field layouts is selected per operation. The source operand is either a register or an immediate input, and one layout always uses the immediate. Writes, flag updates and the reset are synchronous to the rising clock edge. A combinational inspection port reads any register.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears all four registers and the four flags. The status word then equals STATUS_INIT (default 8'hA0). The flag positions are carry bit 0, overflow bit 1, zero bit 2 and negative bit 3.
- R2: Opcode 0 (add) writes dst+src into the destination register, with the result truncated to 32 bits. C is set on unsigned carry-out. V is set when src and dst have equal sign bits and the result's sign bit differs.
- R3: Opcode 1 (subtract) writes dst−src. C is set when src>dst, unsigned. V is set when the operand signs differ and the result sign differs from dst's sign.
- R4: Opcode 2 (compare) evaluates second−first without any register write. The register named by the destination field is the second operand and the source is the first. The flags follow the subtract rules.
- R5: Opcode 3 (OR) and opcode 4 (XOR) write their result and set Z and N from it. They always clear C and V.
- R6: Opcode 5 (bit-test) ANDs src with the destination register without any register write. It sets Z and N from the AND result and clears C and V.
- R7: Z is set exactly when the 32-bit result is zero. N equals bit 31 of the result.
- R8: fmt selects the index fields. fmt 0 uses dst [1:0] and src [3:2]. fmt 1 uses dst [5:4]. fmt 2 uses dst [9:8] and src [11:10]. fmt 3 uses dst [17:16] and src [19:18]. All other instruction bits are ignored.
- R9: The source is the imm input when use_imm is high or fmt is 1. Otherwise it is the register named by the source field.
- R10: When valid is low, or the opcode is 6 or 7, neither the registers nor the status word change.
- R11: Status bits other than the four flags keep their value on every update.
- R12: The register write and the flag update of an operation both take effect on the rising edge where valid is sampled high. Both are visible together after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Execute the presented operation this cycle |
| opcode | input | 3 | Operation code |
| fmt | input | 2 | Index field layout selector |
| instr | input | 32 | Instruction word carrying register index fields |
| use_imm | input | 1 | Take the source from imm instead of a register |
| imm | input | 32 | Immediate source operand |
| peek_idx | input | 2 | Register index for the inspection port |
| peek_data | output | 32 | Contents of register peek_idx |
| status | output | 8 | Status word holding the flags |

## Verification
The bench sweeps all opcodes over a grid of boundary operand values: zero, one, the sign boundaries and all ones. This grid hits the carry-out-versus-overflow distinction in add and the borrow rule in subtract. A design that took carry from the signed comparison, or swapped compare's operand order, would report the wrong C or N on these values. Each field layout is driven with random filler in the unused instruction bits, so a mis-sliced index would write the wrong register. Idle cycles and reserved opcodes are checked for a silent status word and unchanged registers. The non-flag status bits are checked after every operation, which catches an implementation that clears the whole word instead of masking it.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_CMP = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_TST = 3'd5,
      OP_RS6 = 3'd6,
      OP_RS7 = 3'd7
   } alu_op_e;

   localparam int IDX_W = 2;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
      logic v;
   } alu_flags_t;
endpackage

// File: rtl/alu_field_decode.sv
module alu_field_decode
   import alu_flag_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [1:0]         fmt,
   output logic [IDX_W-1:0]   src_idx,
   output logic [IDX_W-1:0]   dst_idx,
   output logic               imm_only
);
   generate
      if (INSTR_W < 20) begin : g_bad_width
         $error("alu_field_decode: INSTR_W must be at least 20");
      end
   endgenerate

   always_comb begin
      src_idx  = '0;
      dst_idx  = '0;
      imm_only = 1'b0;
      unique case (fmt)
         2'd0: begin
            dst_idx = instr[1:0];
            src_idx = instr[3:2];
         end
         2'd1: begin
            dst_idx  = instr[5:4];
            imm_only = 1'b1;
         end
         2'd2: begin
            dst_idx = instr[9:8];
            src_idx = instr[11:10];
         end
         default: begin
            dst_idx = instr[17:16];
            src_idx = instr[19:18];
         end
      endcase
   end
endmodule

// File: rtl/alu_regfile.sv
module alu_regfile
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [DATA_W-1:0] w_data,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [IDX_W-1:0]  rp_idx,
   output logic [DATA_W-1:0] ra_data,
   output logic [DATA_W-1:0] rb_data,
   output logic [DATA_W-1:0] rp_data
);
   localparam int NUM_REGS = 1 << IDX_W;

   logic [DATA_W-1:0] regs [NUM_REGS];

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)
               regs[r] <= '0;
            else if (we && (w_idx == IDX_W'(r)))
               regs[r] <= w_data;
         end
      end
   endgenerate

   assign ra_data = regs[ra_idx];
   assign rb_data = regs[rb_idx];
   assign rp_data = regs[rp_idx];

   // R12
   write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> (regs[$past(w_idx)] == $past(w_data)));
endmodule

// File: rtl/alu_op_core.sv
module alu_op_core
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   output logic [DATA_W-1:0] res,
   output alu_flags_t        flg,
   output logic              wr,
   output logic              known
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] sum_w;
   logic [DATA_W:0] dif_w;
   logic            arith;

   assign sum_w = {1'b0, dst} + {1'b0, src};
   assign dif_w = {1'b0, dst} - {1'b0, src};

   always_comb begin
      res   = '0;
      wr    = 1'b0;
      known = 1'b1;
      arith = 1'b0;
      flg   = '0;
      unique case (op)
         OP_ADD: begin
            res   = sum_w[MSB:0];
            wr    = 1'b1;
            arith = 1'b1;
            flg.c = sum_w[DATA_W];
            flg.v = (src[MSB] == dst[MSB]) && (res[MSB] != dst[MSB]);
         end
         OP_SUB, OP_CMP: begin
            res   = dif_w[MSB:0];
            wr    = (op == OP_SUB);
            arith = 1'b1;
            flg.c = dif_w[DATA_W];
            flg.v = (src[MSB] != dst[MSB]) && (res[MSB] != dst[MSB]);
         end
         OP_OR: begin
            res = dst | src;
            wr  = 1'b1;
         end
         OP_XOR: begin
            res = dst ^ src;
            wr  = 1'b1;
         end
         OP_TST: res = dst & src;
         default: known = 1'b0;
      endcase
      flg.z = (res == '0);
      flg.n = res[MSB];
      if (!arith) begin
         flg.c = 1'b0;
         flg.v = 1'b0;
      end
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                INSTR_W     = 32,
   parameter int                PSW_W       = 8,
   parameter int                POS_C       = 0,
   parameter int                POS_V       = 1,
   parameter int                POS_Z       = 2,
   parameter int                POS_N       = 3,
   parameter logic [PSW_W-1:0]  STATUS_INIT = 8'hA0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               valid,
   input  logic [2:0]         opcode,
   input  logic [1:0]         fmt,
   input  logic [INSTR_W-1:0] instr,
   input  logic               use_imm,
   input  logic [DATA_W-1:0]  imm,
   input  logic [IDX_W-1:0]   peek_idx,
   output logic [DATA_W-1:0]  peek_data,
   output logic [PSW_W-1:0]   status
);
   localparam logic [PSW_W-1:0] FLAG_MASK = (PSW_W'(1) << POS_C) | (PSW_W'(1) << POS_V)
                                          | (PSW_W'(1) << POS_Z) | (PSW_W'(1) << POS_N);

   generate
      if (POS_C >= PSW_W || POS_V >= PSW_W || POS_Z >= PSW_W || POS_N >= PSW_W)
      begin : g_bad_pos
         $error("alu_flag_unit: flag position outside status word");
      end
      if ($countones(FLAG_MASK) != 4) begin : g_dup_pos
         $error("alu_flag_unit: flag positions must be distinct");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("alu_flag_unit: DATA_W too small");
      end
   endgenerate

   alu_op_e           op;
   logic [IDX_W-1:0]  src_idx, dst_idx;
   logic              imm_only;
   logic [DATA_W-1:0] src_reg, dst_reg, src_val, res;
   alu_flags_t        flg;
   logic              core_wr, known, rf_we;

   assign op = alu_op_e'(opcode);

   alu_field_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr    (instr),
      .fmt      (fmt),
      .src_idx  (src_idx),
      .dst_idx  (dst_idx),
      .imm_only (imm_only)
   );

   alu_regfile #(.DATA_W(DATA_W)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we),
      .w_idx   (dst_idx),
      .w_data  (res),
      .ra_idx  (src_idx),
      .rb_idx  (dst_idx),
      .rp_idx  (peek_idx),
      .ra_data (src_reg),
      .rb_data (dst_reg),
      .rp_data (peek_data)
   );

   assign src_val = (use_imm || imm_only) ? imm : src_reg;

   alu_op_core #(.DATA_W(DATA_W)) u_core (
      .op    (op),
      .src   (src_val),
      .dst   (dst_reg),
      .res   (res),
      .flg   (flg),
      .wr    (core_wr),
      .known (known)
   );

   assign rf_we = valid && core_wr;

   always_ff @(posedge clk) begin
      if (rst) begin
         status <= STATUS_INIT & ~FLAG_MASK;
      end else if (valid && known) begin
         status[POS_Z] <= flg.z;
         status[POS_N] <= flg.n;
         status[POS_C] <= flg.c;
         status[POS_V] <= flg.v;
      end
   end

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid || !known) |=> $stable(status));

   // R11
   keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(status & ~FLAG_MASK));

   // R5
   logic_cv_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && (op == OP_OR || op == OP_XOR || op == OP_TST))
      |=> (!status[POS_C] && !status[POS_V]));

   // R4
   no_write_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_CMP || op == OP_TST || !valid) |-> !rf_we);

   // R2
   add_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && op == OP_ADD) |-> (flg.c == ((res < src_val) || (res < dst_reg))));

   // R3
   sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && (op == OP_SUB || op == OP_CMP)) |-> (flg.c == (src_val > dst_reg)));
endmodule

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        valid;
   logic [2:0]  opcode;
   logic [1:0]  fmt;
   logic [31:0] instr;
   logic        use_imm;
   logic [31:0] imm;
   logic [1:0]  peek_idx;
   logic [31:0] peek_data;
   logic [7:0]  status;

   always #10 clk = ~clk;

   alu_flag_unit dut_i (
      .clk(clk), .rst(rst), .valid(valid), .opcode(opcode), .fmt(fmt),
      .instr(instr), .use_imm(use_imm), .imm(imm), .peek_idx(peek_idx),
      .peek_data(peek_data), .status(status)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [31:0] m [4];
   logic [7:0]  ms;
   logic [31:0] lcg = 32'h1234_5678;
   logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFF, 32'h8000_0001, 32'h5555_AAAA, 32'hFFFF_FFFE};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, {24'h0, status}, {24'h0, ms});
      for (int r = 0; r < 4; r++) begin
         peek_idx = 2'(r);
         #1;
         chk(req, peek_data, m[r]);
      end
   endtask

   // Flags at bits C=0, V=1, Z=2, N=3 (R1)
   task automatic set_flags(input logic [31:0] res, input logic c, input logic v);
      ms[2] = (res == 32'h0);   // R7
      ms[3] = res[31];
      ms[0] = c;
      ms[1] = v;
   endtask

   task automatic run(input int op, input int f, input int a, input int b,
                      input bit ui, input logic [31:0] iv, input bit vld, input string req);
      logic [31:0] w, s, d, res;
      logic [32:0] wide;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      w = lcg;
      // R8: field layouts, filler in all other bits
      case (f)
         0: w = (w & ~32'hF) | 32'(b) | (32'(a) << 2);
         1: w = (w & ~32'h30) | (32'(b) << 4);
         2: w = (w & ~32'hF00) | (32'(b) << 8) | (32'(a) << 10);
         default: w = (w & ~32'hF0000) | (32'(b) << 16) | (32'(a) << 18);
      endcase
      s = (ui || f == 1) ? iv : m[a];   // R9
      d = m[b];
      if (vld) begin
         case (op)
            0: begin wide = {1'b0, d} + {1'b0, s}; res = wide[31:0];
                  set_flags(res, wide[32], (s[31] == d[31]) && (res[31] != d[31]));
                  m[b] = res; end
            1, 2: begin res = d - s;
                  set_flags(res, s > d, (s[31] != d[31]) && (res[31] != d[31]));
                  if (op == 1) m[b] = res; end
            3: begin res = d | s; set_flags(res, 0, 0); m[b] = res; end
            4: begin res = d ^ s; set_flags(res, 0, 0); m[b] = res; end
            5: begin res = d & s; set_flags(res, 0, 0); end
            default: ;
         endcase
      end
      @(negedge clk);
      valid = vld; opcode = 3'(op); fmt = 2'(f); instr = w; use_imm = ui; imm = iv;
      @(negedge clk);
      valid = 1'b0;
      // R12: write and flags visible together after the edge
      check_all(req);
   endtask

   task automatic load(input int r, input logic [31:0] v);
      run(4, 0, r, r, 0, 32'h0, 1, "R5");   // self-XOR clears
      run(3, 1, 0, r, 1, v, 1, "R5");
   endtask

   function automatic string req_of(input int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3, 4: return "R5";
         5: return "R6";
         default: return "R10";
      endcase
   endfunction

   initial begin
      rst = 1'b1; valid = 1'b0; opcode = '0; fmt = '0; instr = '0;
      use_imm = 1'b0; imm = '0; peek_idx = '0;
      for (int r = 0; r < 4; r++) m[r] = '0;
      ms = 8'hA0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_all("R1");

      // Boundary sweep across all opcodes (R2-R7, R10, R11)
      for (int op = 0; op < 8; op++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
               load(1, vals[i]);
               load(2, vals[j]);
               run(op, (i + j) % 4 == 1 ? 0 : (i + j) % 4, 1, 2, 0, 32'h0, 1, req_of(op));
               run(op, 1, 0, 3, 1, vals[i], 1, req_of(op));
            end

      // R8: every layout with every index pair
      for (int f = 0; f < 4; f++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
               load(a, 32'h100 + 32'(a));
               run(0, f, a, b, 0, 32'h0, 1, "R8");
            end

      // R10: valid low leaves everything untouched
      load(0, 32'h8000_0000);
      run(0, 0, 0, 0, 0, 32'h0, 1, "R2");
      for (int op = 0; op < 8; op++) run(op, 0, 1, 0, 1, 32'hFFFF_FFFF, 0, "R10");

      // R9: immediate overrides the source field
      run(0, 2, 3, 0, 1, 32'h0000_0005, 1, "R9");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #3_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule